// File: doc/BRIEF.md
# Processor Activity Watchdog

This block watches a strobe line that a processor's software is meant to toggle while it runs normally. Any qualified change of level on that line, rising or falling, restarts an internal cycle counter. When the counter reaches the configured time-out with no change seen, the active-low alarm output drops. It stays low until software shows signs of life again with a fresh qualified transition.

The strobe is brought into the clock domain through a synchronizer. A level change is accepted only after the new level has held for a minimum number of cycles, so fast chatter and glitches never restart the count. While the chip's system reset is held, which includes its recovery period, the counter is held at zero and cannot trip. It begins counting again on its own once reset releases. A flag from an external tri-state detector reports when the strobe line is floating or undriven, and while it does the watchdog is held idle. A supply-good flag forces the alarm low immediately, without passing through any register, whenever the supply is bad.

Top module: `wd_supervisor`

## Requirements
- R1: After the block reset `rst_ni` releases, with the supply good, `wdo_no` is 1 and the counter is at zero.
- R2: A qualified strobe transition in either direction restarts the count from zero. Strobe activity with transitions spaced closer than the time-out keeps `wdo_no` at 1 indefinitely.
- R3: If no qualified transition reaches the counter for `TIMEOUT_CYC` consecutive counting cycles, `wdo_no` goes to 0.
- R4: A strobe level that holds for fewer than `MIN_PULSE` cycles after synchronization is discarded and does not restart the count. A level that holds `MIN_PULSE` cycles qualifies.
- R5: While `supply_ok_i` is 0, `wdo_no` is 0 in the same cycle, whether or not a time-out has happened.
- R6: While `sys_rst_i` is 1, the counter is held at zero and any trip is cleared, so `wdo_no` is 1 if the supply is good. Counting restarts from zero on the first cycle after `sys_rst_i` falls.
- R7: While `wdi_driven_i` is 0, the watchdog is disabled. The counter is held at zero, no trip can occur and `wdo_no` is 1 if the supply is good.
- R8: After a trip, `wdo_no` stays 0 until a qualified transition arrives. That transition clears the trip, `wdo_no` returns to 1, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's registers |
| sys_rst_i | input | 1 | System reset including recovery period, active high; holds the watchdog cleared |
| supply_ok_i | input | 1 | Supply-good flag; 0 forces the alarm low at once |
| wdi_i | input | 1 | Activity strobe from software, asynchronous |
| wdi_driven_i | input | 1 | 1 when the strobe line is actively driven; 0 disables the watchdog |
| wdo_no | output | 1 | Watchdog alarm, active low |

## Verification
A counter that is off by one, or a filter that qualifies one cycle early or late, moves the alarm edge by a cycle. The bench model compares the output every clock, so such a fault is seen on the exact cycle the trip should or should not happen. A trip that fails to stick, or a hold that does not clear the count, shows up within one time-out window as an alarm that rises or falls where the model disagrees. A filter that passes short glitches shows up as an alarm that never appears during a burst of sub-threshold pulses longer than the time-out.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic [1:0] {
        WD_HOLD = 2'd0,
        WD_RUN  = 2'd1,
        WD_TRIP = 2'd2
    } wd_state_e;

    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/wd_sync.sv
module wd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = async_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/wd_filter.sv
module wd_filter #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic hit_o
);
    localparam int CW = wd_pkg::cnt_bits(MIN_PULSE + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
        logic          hit;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d     = flt_q;
        flt_d.hit = 1'b0;
        if (level_i == flt_q.lvl) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == LAST) begin
            flt_d.lvl = level_i;
            flt_d.cnt = '0;
            flt_d.hit = 1'b1;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flt_q <= '0;
        else         flt_q <= flt_d;
    end

    assign hit_o = flt_q.hit;

    generate
        if (MIN_PULSE > 1) begin : g_spacing
            AST_HIT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
                hit_o |=> !hit_o);  // R4
        end
    endgenerate

    AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hit_o) |-> $changed(flt_q.lvl));  // R4
endmodule

// File: rtl/wd_timer.sv
module wd_timer #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    input  logic hit_i,
    output logic trip_o
);
    import wd_pkg::*;

    localparam int TW = cnt_bits(TIMEOUT_CYC);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        wd_state_e     st;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (hold_i) begin
            tmr_d.cnt = '0;
            tmr_d.st  = WD_HOLD;
        end else if (hit_i) begin
            tmr_d.cnt = '0;
            tmr_d.st  = WD_RUN;
        end else if (tmr_q.st != WD_TRIP) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.cnt = '0;
                tmr_d.st  = WD_TRIP;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
                tmr_d.st  = WD_RUN;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '{cnt: '0, st: WD_HOLD};
        else         tmr_q <= tmr_d;
    end

    assign trip_o = (tmr_q.st == WD_TRIP);

    AST_HOLD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> (tmr_q.cnt == '0) && !trip_o);  // R6
    AST_HIT_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_i && !hold_i) |=> (tmr_q.cnt == '0) && !trip_o);  // R2
    AST_TRIP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trip_o && !hit_i && !hold_i) |=> trip_o);  // R8
    AST_TRIP_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(trip_o) |-> ($past(tmr_q.cnt) == LAST));  // R3
endmodule

// File: rtl/wd_supervisor.sv
module wd_supervisor #(
    parameter int TIMEOUT_CYC = 1000,
    parameter int MIN_PULSE   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sys_rst_i,
    input  logic supply_ok_i,
    input  logic wdi_i,
    input  logic wdi_driven_i,
    output logic wdo_no
);
    logic wdi_sync;
    logic wdi_hit;
    logic trip;

    wd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (wdi_i),
        .sync_o  (wdi_sync)
    );

    wd_filter #(.MIN_PULSE(MIN_PULSE)) u_filter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (wdi_sync),
        .hit_o   (wdi_hit)
    );

    wd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hold_i  (sys_rst_i | ~wdi_driven_i),
        .hit_i   (wdi_hit),
        .trip_o  (trip)
    );

    assign wdo_no = supply_ok_i & ~trip;

    AST_DISABLED_NO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wdi_driven_i && supply_ok_i) |=> (wdo_no || !supply_ok_i));  // R7
endmodule

// File: tb/wd_supervisor_tb_top.sv
module wd_supervisor_tb_top;
    localparam int TO = 64;
    localparam int MP = 4;
    localparam int SY = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_rst = 1'b0;
    logic supply = 1'b1;
    logic wdi = 1'b0;
    logic drv = 1'b1;
    logic wdo_n;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    wd_supervisor #(.TIMEOUT_CYC(TO), .MIN_PULSE(MP), .SYNC_STAGES(SY)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sys_rst_i    (sys_rst),
        .supply_ok_i  (supply),
        .wdi_i        (wdi),
        .wdi_driven_i (drv),
        .wdo_no       (wdo_n)
    );

    // behavioural reference
    bit m_pipe[$];
    bit m_lvl;
    int m_fcnt;
    bit m_hit;
    int m_tcnt;
    bit m_trip;

    initial begin
        for (int i = 0; i < SY; i++) m_pipe.push_back(1'b0);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pipe.delete();
            for (int i = 0; i < SY; i++) m_pipe.push_back(1'b0);
            m_lvl = 0; m_fcnt = 0; m_hit = 0; m_tcnt = 0; m_trip = 0;
        end else begin
            bit seen;
            seen = m_pipe[0];
            if (sys_rst || !drv) begin
                m_tcnt = 0; m_trip = 0;
            end else if (m_hit) begin
                m_tcnt = 0; m_trip = 0;
            end else if (!m_trip) begin
                m_tcnt++;
                if (m_tcnt >= TO) begin m_tcnt = 0; m_trip = 1; end
            end
            m_hit = 0;
            if (seen == m_lvl) m_fcnt = 0;
            else begin
                m_fcnt++;
                if (m_fcnt >= MP) begin m_lvl = seen; m_fcnt = 0; m_hit = 1; end
            end
            void'(m_pipe.pop_front());
            m_pipe.push_back(wdi);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit exp;
            exp = supply & ~m_trip;
            tests++;
            if (wdo_n !== exp) begin
                fails++;
                $display("FAIL %s: cycle compare wdo_no got %b expected %b", cur_req, wdo_n, exp);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input string req, input bit exp);
        @(negedge clk);
        tests++;
        if (wdo_n !== exp) begin
            fails++;
            $display("FAIL %s: wdo_no got %b expected %b", req, wdo_n, exp);
        end
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        cur_req = "R1";
        chk("R1", 1'b1);

        // R2: both edges keep it alive
        cur_req = "R2";
        for (int i = 0; i < 12; i++) begin step(30); wdi = ~wdi; end
        step(20);
        chk("R2", 1'b1);

        // R3: silence trips
        cur_req = "R3";
        step(TO + 20);
        chk("R3", 1'b0);

        // R8: sticky until a qualified edge
        cur_req = "R8";
        step(50);
        chk("R8", 1'b0);
        wdi = ~wdi;
        step(12);
        chk("R8", 1'b1);

        // R4: short glitches do not clear
        cur_req = "R4";
        for (int i = 0; i < 14; i++) begin
            step(8); wdi = ~wdi; step(MP - 1); wdi = ~wdi;
        end
        for (int i = 0; i < 10; i++) begin
            step(6); wdi = ~wdi; step(1); wdi = ~wdi;
        end
        chk("R4", 1'b0);
        // a pulse exactly MP wide qualifies
        wdi = ~wdi; step(MP); wdi = ~wdi;
        step(12);
        chk("R4", 1'b1);

        // R5: supply loss is immediate
        cur_req = "R5";
        step(5);
        supply = 1'b0;
        #0.5;
        tests++;
        if (wdo_n !== 1'b0) begin
            fails++;
            $display("FAIL R5: wdo_no got %b expected 0", wdo_n);
        end
        step(3);
        chk("R5", 1'b0);
        supply = 1'b1;
        wdi = ~wdi;
        step(12);
        chk("R5", 1'b1);

        // R6: system reset holds and counting restarts after release
        cur_req = "R6";
        step(TO + 20);
        chk("R6", 1'b0);
        sys_rst = 1'b1;
        step(3);
        chk("R6", 1'b1);
        step(3 * TO);
        chk("R6", 1'b1);
        sys_rst = 1'b0;
        step(TO - 4);
        chk("R6", 1'b1);
        step(8);
        chk("R6", 1'b0);

        // R7: undriven line disables
        cur_req = "R7";
        drv = 1'b0;
        step(3);
        chk("R7", 1'b1);
        for (int i = 0; i < 6; i++) begin step(40); wdi = ~wdi; end
        step(2 * TO);
        chk("R7", 1'b1);
        drv = 1'b1;
        step(TO + 20);
        chk("R7", 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule